// File: doc/BRIEF.md
# Interrupt Pending and Acknowledge Controller

This block collects interrupt requests from internal event sources into an 8-bit pending field and drives one level-sensitive interrupt line to the host. The pending field is shown to the host as the upper byte of a 16-bit status word. The lower byte of that word is always zero. An event source raises a request by presenting the upper byte of its 16-bit type mask, normally with a single bit set. The host clears pending bits by writing an acknowledge byte whose bits line up with the pending field.

A global mask flag is written through its own command strobe. While the flag is set, new requests are dropped: they are not stored for later and they do not raise the line. A faulty acknowledge is rejected and changes nothing. That covers a write of zero and a write with no bit in common with the pending field.

The line is held by a two-state machine. Its states are `LINE_IDLE` (line low) and `LINE_RAISED` (line high), with two transitions:
- `LINE_IDLE` to `LINE_RAISED` on an accepted event (`take_raise`).
- `LINE_RAISED` to `LINE_IDLE` on a valid acknowledge that leaves the pending field empty (`take_drop`).

Top module: `irq_stat_ack_ctrl`

## Requirements
- R1: A low level on `rst_n` clears the pending field, the interrupt line and the mask flag. After reset, `status_word` reads 16'h0000 and `irq_line` reads 0.
- R2: An event accepted in cycle t is seen in the status word from cycle t+1. An event is accepted when `evt_valid` is 1, the mask flag is 0 and `evt_bits` is non-zero. Accepting it ORs `evt_bits` into `status_word[15:8]`.
- R3: While the mask flag is 1, an event changes neither `status_word` nor `irq_line`.
- R4: A write with `cmd_we` stores `cmd_mask` into the mask flag at the clock edge. An event presented in the same cycle as that write is judged with the old flag value.
- R5: A valid acknowledge clears exactly the pending bits that are set in `ack_data`. Bit n of `ack_data` matches bit n+8 of `status_word`. An acknowledge is valid when it has at least one bit in common with the pending field. Its bits that are not pending have no effect.
- R6: An acknowledge of 8'h00 is rejected and leaves `status_word` and `irq_line` unchanged.
- R7: An acknowledge with no bit in common with the pending field is rejected and leaves `status_word` and `irq_line` unchanged.
- R8: `irq_line` rises one cycle after an accepted event. It falls only in the cycle after a valid acknowledge that empties the pending field. While any bit is still pending, the line stays high.
- R9: If an event and a valid acknowledge name the same bit in the same cycle, the event wins: that bit stays pending and the line stays high.
- R10: An event whose `evt_bits` is 8'h00 has no effect on `status_word` or `irq_line`.
- R11: `status_word[7:0]` is always 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event source presents a request this cycle |
| evt_bits | input | 8 | Upper byte of the event's type mask |
| ack_we | input | 1 | Host acknowledge write strobe |
| ack_data | input | 8 | Acknowledge byte; bit n clears pending bit n |
| cmd_we | input | 1 | Host command write strobe |
| cmd_mask | input | 1 | Global mask value written by `cmd_we` |
| status_word | output | 16 | Pending field in [15:8], zero in [7:0] |
| irq_line | output | 1 | Level-sensitive interrupt request |

## Verification
The bench drives an event and a matching acknowledge in the same cycle. A design that lets the acknowledge win would drop the line while a request is still outstanding. It sends an acknowledge that partly overlaps the pending field and then the one that empties it. This catches a line that falls too early, and a clear that also removes bits that were never acknowledged. It writes the mask in the same cycle as an event, and sends a masked event while nothing is pending. A design that latched masked requests, or used the new mask value too early, would show the wrong status byte. Finally it sends rejected acknowledges (zero, and with no overlap). A design that applied them anyway would corrupt the visible byte or lower the line.

// File: rtl/irq_sa_pkg.sv
package irq_sa_pkg;
    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic cmd_mask,
    output logic mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (cmd_we) begin
            mask_q <= cmd_mask;
        end
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_take,
    input  logic [PEND_W-1:0] evt_bits,
    input  logic              ack_we,
    input  logic [PEND_W-1:0] ack_data,
    output logic              ack_ok,
    output logic [PEND_W-1:0] pend_next,
    output logic [PEND_W-1:0] pend_q
);
    logic [PEND_W-1:0] after_ack;

    always_comb begin
        ack_ok    = ack_we && (|(ack_data & pend_q));
        after_ack = ack_ok ? (pend_q & ~ack_data) : pend_q;
        pend_next = evt_take ? (after_ack | evt_bits) : after_ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_next;
        end
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_sa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_raise,
    input  logic ack_ok,
    input  logic pend_next_zero,
    output logic irq_line
);
    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE: begin
                if (take_raise) begin
                    state_d = LINE_RAISED;
                end
            end
            LINE_RAISED: begin
                if (ack_ok && pend_next_zero) begin
                    state_d = LINE_IDLE;
                end
            end
            default: state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LINE_IDLE:   irq_line = 1'b0;
            LINE_RAISED: irq_line = 1'b1;
            default:     irq_line = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_stat_ack_ctrl.sv
module irq_stat_ack_ctrl #(
    parameter int PEND_W = 8,
    localparam int STAT_W = 2 * PEND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [PEND_W-1:0] evt_bits,
    input  logic              ack_we,
    input  logic [PEND_W-1:0] ack_data,
    input  logic              cmd_we,
    input  logic              cmd_mask,
    output logic [STAT_W-1:0] status_word,
    output logic              irq_line
);
    logic              mask_q;
    logic              evt_take;
    logic              ack_ok;
    logic [PEND_W-1:0] pend_next;
    logic [PEND_W-1:0] pend_q;

    assign evt_take = evt_valid && !mask_q && (|evt_bits);

    irq_mask_reg u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_mask (cmd_mask),
        .mask_q   (mask_q)
    );

    irq_pend_reg #(.PEND_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_take  (evt_take),
        .evt_bits  (evt_bits),
        .ack_we    (ack_we),
        .ack_data  (ack_data),
        .ack_ok    (ack_ok),
        .pend_next (pend_next),
        .pend_q    (pend_q)
    );

    irq_line_fsm u_line (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_raise     (evt_take),
        .ack_ok         (ack_ok),
        .pend_next_zero (pend_next == '0),
        .irq_line       (irq_line)
    );

    assign status_word = {pend_q, {PEND_W{1'b0}}};
endmodule

// File: rtl/irq_sa_checker.sv
module irq_sa_checker #(
    parameter int PEND_W = 8,
    localparam int STAT_W = 2 * PEND_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [PEND_W-1:0] evt_bits,
    input logic              ack_we,
    input logic [PEND_W-1:0] ack_data,
    input logic              mask_q,
    input logic [STAT_W-1:0] status_word,
    input logic              irq_line
);
    logic [PEND_W-1:0] vis;
    logic              take;
    assign vis  = status_word[STAT_W-1:PEND_W];
    assign take = evt_valid && !mask_q && (|evt_bits);

    a_r8_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line == (vis != '0));

    a_r11_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[PEND_W-1:0] == '0);

    a_r2_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((vis & $past(evt_bits)) == $past(evt_bits)) && irq_line);

    a_r3_masked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && evt_valid && !ack_we) |=> $stable(status_word) && $stable(irq_line));

    a_r6_zero_ack_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_data == '0 && !take) |=> $stable(status_word));

    a_r7_no_overlap_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && (ack_data & vis) == '0 && !take) |=> $stable(status_word));

    a_r5_acked_bits_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && (ack_data & vis) != '0 && !take) |=>
            (vis & $past(ack_data)) == '0 && (vis | $past(ack_data)) == ($past(vis) | $past(ack_data)));
endmodule

bind irq_stat_ack_ctrl irq_sa_checker #(.PEND_W(PEND_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_bits    (evt_bits),
    .ack_we      (ack_we),
    .ack_data    (ack_data),
    .mask_q      (mask_q),
    .status_word (status_word),
    .irq_line    (irq_line)
);

// File: tb/irq_stat_ack_ctrl_test.sv
`timescale 1ns/1ps
module irq_stat_ack_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_bits = '0;
    logic        ack_we = 1'b0;
    logic [7:0]  ack_data = '0;
    logic        cmd_we = 1'b0;
    logic        cmd_mask = 1'b0;
    logic [15:0] status_word;
    logic        irq_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_stat_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_bits(evt_bits),
        .ack_we(ack_we), .ack_data(ack_data), .cmd_we(cmd_we), .cmd_mask(cmd_mask),
        .status_word(status_word), .irq_line(irq_line)
    );

    task automatic chk(string req, logic [15:0] st_exp, logic irq_exp);
        n_cmp++;
        if (status_word !== st_exp || irq_line !== irq_exp) begin
            n_bad++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, status_word, irq_line, st_exp, irq_exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs are valid at the next falling edge.
    task automatic step(logic ev, logic [7:0] eb, logic aw, logic [7:0] ad, logic cw, logic cm);
        evt_valid = ev; evt_bits = eb; ack_we = aw; ack_data = ad; cmd_we = cw; cmd_mask = cm;
        @(negedge clk);
        evt_valid = 1'b0; evt_bits = '0; ack_we = 1'b0; ack_data = '0; cmd_we = 1'b0; cmd_mask = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 reset state", 16'h0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", 16'h0000, 1'b0);
    endtask

    task automatic t_events();
        step(1, 8'h20, 0, 8'h00, 0, 0);
        chk("R2 first event", 16'h2000, 1'b1);
        step(1, 8'h80, 0, 8'h00, 0, 0);
        chk("R2 second event ORs in", 16'hA000, 1'b1);
        step(1, 8'h00, 0, 8'h00, 0, 0);
        chk("R10 empty event", 16'hA000, 1'b1);
    endtask

    task automatic t_bad_acks();
        step(0, 8'h00, 1, 8'h00, 0, 0);
        chk("R6 zero ack", 16'hA000, 1'b1);
        step(0, 8'h00, 1, 8'h01, 0, 0);
        chk("R7 non-overlap ack", 16'hA000, 1'b1);
    endtask

    task automatic t_partial_and_race();
        step(0, 8'h00, 1, 8'h21, 0, 0);
        chk("R5 partial ack clears only bit 13", 16'h8000, 1'b1);
        step(1, 8'h80, 1, 8'h80, 0, 0);
        chk("R9 event beats ack", 16'h8000, 1'b1);
        step(0, 8'h00, 1, 8'h80, 0, 0);
        chk("R8 line falls after last ack", 16'h0000, 1'b0);
    endtask

    task automatic t_mask();
        step(1, 8'h04, 0, 8'h00, 1, 1);
        chk("R4 event uses old mask", 16'h0400, 1'b1);
        step(1, 8'h02, 0, 8'h00, 0, 0);
        chk("R3 masked event while pending", 16'h0400, 1'b1);
        step(0, 8'h00, 1, 8'h04, 0, 0);
        chk("R5 clear under mask", 16'h0000, 1'b0);
        step(1, 8'h10, 0, 8'h00, 0, 0);
        chk("R3 masked event while empty", 16'h0000, 1'b0);
        step(0, 8'h00, 0, 8'h00, 1, 0);
        chk("R4 unmask write alone", 16'h0000, 1'b0);
        step(1, 8'h01, 0, 8'h00, 0, 0);
        chk("R4 event after unmask", 16'h0100, 1'b1);
    endtask

    task automatic t_reset_mid();
        step(1, 8'h40, 0, 8'h00, 1, 1);
        chk("R2 event before reset", 16'h4100, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears pending", 16'h0000, 1'b0);
        step(1, 8'h08, 0, 8'h00, 0, 0);
        chk("R1 reset clears mask", 16'h0800, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_events();
        t_bad_acks();
        t_partial_and_race();
        t_mask();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule